// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block keeps the two status words of an I2C controller and applies their clearing rules. The protocol engine reports events and errors as one-cycle set pulses. Software reaches the flags through a small register bus that has read and write strobes, a word address, write data and combinational read data. Five event flags are cleared by a two-access sequence. The first access is a read of the first status word. The access that immediately follows it must be the one that flag is waiting for. Seven error flags are cleared when software writes zero to their bits.

Three interrupt lines are gated by enable bits in the second control word: one for events, one for buffer state and one for errors. The two status words are also presented together as a 24-bit "last event" vector. Software can compare this vector against event patterns in a single read.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset every event and error flag is 0, the control words and the data byte are 0, and all three interrupt outputs are low. Word addresses: 0 control A, 1 control B, 2 data (the low 8 bits, read back zero-extended), 3 status word 1, 4 status word 2. Read data is combinational from the address. Unmapped addresses read 0.
- R2: A start pulse sets status word 1 bit 0. The flag clears when a read of status word 1 is immediately followed by a write to the data address.
- R3: An address pulse sets status word 1 bit 1. The flag clears when a read of status word 1 is immediately followed by a read of status word 2.
- R4: A byte-finished pulse sets status word 1 bit 2. The flag clears when a read of status word 1 is immediately followed by either a read or a write of the data address.
- R5: A 10-bit-header pulse sets status word 1 bit 3. The flag clears when a read of status word 1 is immediately followed by a write of the data address. A data read does not clear it.
- R6: A stop pulse sets status word 1 bit 4. The flag clears when a read of status word 1 is immediately followed by a write to control A. A write to any other address does not clear it.
- R7: A status word 1 read arms clearing only for the event flags that are set during that read. Any other bus access drops the arming. A flag set after the read, or a qualifying access that comes after some other access, leaves the flag set. Writes to status word 1 never change bits 0 to 4.
- R8: Error pulses set status word 1 bits 8 to 14: bit 8 bus error, bit 9 arbitration lost, bit 10 acknowledge failure, bit 11 overrun, bit 12 check-code error, bit 13 timeout, bit 14 alert. A write to status word 1 clears each error bit written 0 and leaves each error bit written 1 as it was.
- R9: When a set pulse and a clearing access hit the same flag in the same cycle, the flag ends the cycle set.
- R10: The enable bits are control B bit 8 (event), bit 9 (buffer) and bit 10 (error). The event interrupt is high when its enable is on and any of bits 0 to 4 is set. The error interrupt is high when its enable is on and any of bits 8 to 14 is set. The buffer interrupt is high when its enable is on and a live buffer input is high. Those inputs are receive-full, shown at status word 1 bit 6, and transmit-empty, shown at bit 7.
- R11: Status word 2 shows the check-code byte input in bits 15:8 and the 3-bit bus state input in bits 2:0. Its other bits read 0.
- R12: The last-event output is status word 2 shifted left by 16, ORed with status word 1, and kept to its low 24 bits. The check-code byte is therefore not part of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| evt_set_i | input | 5 | Event set pulses (start, address, byte, header, stop) |
| err_set_i | input | 7 | Error set pulses in status bit order |
| rx_full_i | input | 1 | Receive byte waiting (live) |
| tx_empty_i | input | 1 | Transmit byte slot free (live) |
| state_i | input | 3 | Bus state bits for status word 2 |
| pec_i | input | 8 | Computed check-code byte |
| irq_evt_o | output | 1 | Event interrupt |
| irq_buf_o | output | 1 | Buffer interrupt |
| irq_err_o | output | 1 | Error interrupt |
| last_evt_o | output | 24 | Packed last-event view |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 3-bit address, five event flags, seven error flags and an 8-bit check-code byte. With these values the 24-bit view ends exactly at the check-code byte. A bench check can therefore show that the state bits of status word 2 land at view bits 18:16 and that the check-code byte is left out. The same values place the error field at bits 8 to 14. This lets write-zero patterns clear a single error bit while the event bits 0 to 4 stay untouched in the same word.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int N_EVT   = 5;
    localparam int N_ERR   = 7;
    localparam int ERR_LSB = 8;
    localparam int RXF_BIT = 6;
    localparam int TXE_BIT = 7;

    // event flag positions in status word 1
    localparam int EV_START = 0;
    localparam int EV_ADDR  = 1;
    localparam int EV_BYTE  = 2;
    localparam int EV_HDR   = 3;
    localparam int EV_STOP  = 4;

    // interrupt enable positions in control B
    localparam int IE_EVT = 8;
    localparam int IE_BUF = 9;
    localparam int IE_ERR = 10;

    // word addresses
    localparam logic [2:0] A_CTLA = 3'd0;
    localparam logic [2:0] A_CTLB = 3'd1;
    localparam logic [2:0] A_DATA = 3'd2;
    localparam logic [2:0] A_STS1 = 3'd3;
    localparam logic [2:0] A_STS2 = 3'd4;

    // decoded bus access seen by the sequence clearing logic
    typedef struct packed {
        logic any;
        logic sts1_rd;
        logic sts2_rd;
        logic data_rd;
        logic data_wr;
        logic ctla_wr;
    } acc_t;

    typedef struct packed {
        logic [N_EVT-1:0] flags;
        logic [N_EVT-1:0] mark;
    } seq_st_t;

endpackage

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags
    import i2c_stat_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] set_i,
    input  acc_t             acc_i,
    output logic [N_EVT-1:0] flags_o
);

    seq_st_t          st_d, st_q;
    logic [N_EVT-1:0] qual;
    logic [N_EVT-1:0] clr;

    // which follow-up access releases each flag
    always_comb begin
        qual           = '0;
        qual[EV_START] = acc_i.data_wr;
        qual[EV_ADDR]  = acc_i.sts2_rd;
        qual[EV_BYTE]  = acc_i.data_wr | acc_i.data_rd;
        qual[EV_HDR]   = acc_i.data_wr;
        qual[EV_STOP]  = acc_i.ctla_wr;
    end

    always_comb begin
        st_d = st_q;
        clr  = st_q.mark & qual;
        if (acc_i.sts1_rd) begin
            st_d.mark = st_q.flags;
        end else if (acc_i.any) begin
            st_d.mark = '0;
        end
        st_d.flags = (st_q.flags & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags
    import i2c_stat_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_ERR-1:0] set_i,
    input  logic             wr_i,
    input  logic [N_ERR-1:0] wbits_i,
    output logic [N_ERR-1:0] flags_o
);

    logic [N_ERR-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_i) begin
            flags_d = flags_q & wbits_i;
        end
        flags_d = flags_d | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/i2c_irq_gate.sv
module i2c_irq_gate
    import i2c_stat_pkg::*;
(
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_ERR-1:0] err_i,
    input  logic [1:0]       buf_i,
    input  logic [2:0]       en_i,
    output logic             irq_evt_o,
    output logic             irq_buf_o,
    output logic             irq_err_o
);

    always_comb begin
        irq_evt_o = en_i[0] & (|evt_i);
        irq_buf_o = en_i[1] & (|buf_i);
        irq_err_o = en_i[2] & (|err_i);
    end

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int N_STATE = 3,
    parameter int PEC_W   = 8,
    parameter int VIEW_W  = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [N_EVT-1:0]  evt_set_i,
    input  logic [N_ERR-1:0]  err_set_i,
    input  logic              rx_full_i,
    input  logic              tx_empty_i,
    input  logic [N_STATE-1:0] state_i,
    input  logic [PEC_W-1:0]  pec_i,
    output logic              irq_evt_o,
    output logic              irq_buf_o,
    output logic              irq_err_o,
    output logic [VIEW_W-1:0] last_evt_o
);

    localparam int VIEW_HI = VIEW_W - REG_W;

    typedef struct packed {
        logic [REG_W-1:0]  ctla;
        logic [REG_W-1:0]  ctlb;
        logic [DATA_W-1:0] dat;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    acc_t             acc_w;
    logic             sts1_wr_w;
    logic [N_EVT-1:0] evt_flags_w;
    logic [N_ERR-1:0] err_flags_w;
    logic [REG_W-1:0] sts1_w;
    logic [REG_W-1:0] sts2_w;
    logic [2:0]       irq_en_w;

    // access decode
    always_comb begin
        acc_w.any     = rd_i | wr_i;
        acc_w.sts1_rd = rd_i & (addr_i == ADDR_W'(A_STS1));
        acc_w.sts2_rd = rd_i & (addr_i == ADDR_W'(A_STS2));
        acc_w.data_rd = rd_i & (addr_i == ADDR_W'(A_DATA));
        acc_w.data_wr = wr_i & (addr_i == ADDR_W'(A_DATA));
        acc_w.ctla_wr = wr_i & (addr_i == ADDR_W'(A_CTLA));
        sts1_wr_w     = wr_i & (addr_i == ADDR_W'(A_STS1));
    end

    // control words and data byte
    always_comb begin
        st_d = st_q;
        if (acc_w.ctla_wr) begin
            st_d.ctla = wdata_i;
        end
        if (wr_i && addr_i == ADDR_W'(A_CTLB)) begin
            st_d.ctlb = wdata_i;
        end
        if (acc_w.data_wr) begin
            st_d.dat = wdata_i[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    i2c_seq_flags u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (evt_set_i),
        .acc_i   (acc_w),
        .flags_o (evt_flags_w)
    );

    i2c_err_flags u_err (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (err_set_i),
        .wr_i    (sts1_wr_w),
        .wbits_i (wdata_i[ERR_LSB +: N_ERR]),
        .flags_o (err_flags_w)
    );

    assign irq_en_w = {st_q.ctlb[IE_ERR], st_q.ctlb[IE_BUF], st_q.ctlb[IE_EVT]};

    i2c_irq_gate u_irq (
        .evt_i     (evt_flags_w),
        .err_i     (err_flags_w),
        .buf_i     ({tx_empty_i, rx_full_i}),
        .en_i      (irq_en_w),
        .irq_evt_o (irq_evt_o),
        .irq_buf_o (irq_buf_o),
        .irq_err_o (irq_err_o)
    );

    // status word assembly
    always_comb begin
        sts1_w                      = '0;
        sts1_w[N_EVT-1:0]           = evt_flags_w;
        sts1_w[RXF_BIT]             = rx_full_i;
        sts1_w[TXE_BIT]             = tx_empty_i;
        sts1_w[ERR_LSB +: N_ERR]    = err_flags_w;
        sts2_w                      = '0;
        sts2_w[N_STATE-1:0]         = state_i;
        sts2_w[REG_W-1 -: PEC_W]    = pec_i;
    end

    assign last_evt_o = {sts2_w[VIEW_HI-1:0], sts1_w};

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_CTLA): rdata_o = st_q.ctla;
            ADDR_W'(A_CTLB): rdata_o = st_q.ctlb;
            ADDR_W'(A_DATA): rdata_o = REG_W'(st_q.dat);
            ADDR_W'(A_STS1): rdata_o = sts1_w;
            ADDR_W'(A_STS2): rdata_o = sts2_w;
            default:         rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk
    import i2c_stat_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 3,
    parameter int VIEW_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic [N_EVT-1:0]  evt_set_i,
    input logic [N_ERR-1:0]  err_set_i,
    input logic [REG_W-1:0]  sts1_i,
    input logic [2:0]        irq_en_i,
    input logic              irq_err_o,
    input logic              irq_evt_o,
    input logic [VIEW_W-1:0] last_evt_o
);

    // R9
    evt_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |evt_set_i |=> ((sts1_i[N_EVT-1:0] & $past(evt_set_i)) == $past(evt_set_i)));

    // R9
    err_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |err_set_i |=> ((sts1_i[ERR_LSB +: N_ERR] & $past(err_set_i)) == $past(err_set_i)));

    // R8
    err_rise_needs_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((sts1_i[ERR_LSB +: N_ERR] & ~$past(sts1_i[ERR_LSB +: N_ERR])
                   & ~$past(err_set_i)) == '0));

    // R2
    start_fall_on_data_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sts1_i[EV_START]) |-> $past(wr_i && addr_i == ADDR_W'(A_DATA)));

    // R6
    stop_fall_on_ctla_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sts1_i[EV_STOP]) |-> $past(wr_i && addr_i == ADDR_W'(A_CTLA)));

    // R10
    err_irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_err_o |-> irq_en_i[2]);

    // R10
    evt_irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_evt_o |-> irq_en_i[0]);

    // R12
    view_matches_sts1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADDR_W'(A_STS1)) |-> (rdata_o == last_evt_o[REG_W-1:0]));

endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .VIEW_W (VIEW_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .evt_set_i  (evt_set_i),
    .err_set_i  (err_set_i),
    .sts1_i     (sts1_w),
    .irq_en_i   (irq_en_w),
    .irq_err_o  (irq_err_o),
    .irq_evt_o  (irq_evt_o),
    .last_evt_o (last_evt_o)
);

// File: tb/i2c_stat_flags_tb.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb;

    localparam logic [2:0] CA = 3'd0;
    localparam logic [2:0] CB = 3'd1;
    localparam logic [2:0] DT = 3'd2;
    localparam logic [2:0] S1 = 3'd3;
    localparam logic [2:0] S2 = 3'd4;
    localparam int WDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  evt_set = '0;
    logic [6:0]  err_set = '0;
    logic        rx_full = 1'b0;
    logic        tx_empty = 1'b0;
    logic [2:0]  state = 3'b101;
    logic [7:0]  pec = 8'h5A;
    logic        irq_evt, irq_buf, irq_err;
    logic [23:0] last_evt;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] e_val;
    string       e_tag;

    always #5 clk = ~clk;

    i2c_stat_flags u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rd_i       (rd),
        .wr_i       (wr),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .evt_set_i  (evt_set),
        .err_set_i  (err_set),
        .rx_full_i  (rx_full),
        .tx_empty_i (tx_empty),
        .state_i    (state),
        .pec_i      (pec),
        .irq_evt_o  (irq_evt),
        .irq_buf_o  (irq_buf),
        .irq_err_o  (irq_err),
        .last_evt_o (last_evt)
    );

    // monitor: compare read data mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h", rdata);
            end else begin
                e_val = exp_q.pop_front();
                e_tag = tag_q.pop_front();
                n_vec++;
                if (rdata !== e_val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e_tag, rdata, e_val);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1; addr = a;
        step();
        rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic pulse_evt(input logic [4:0] m);
        evt_set = m; step(); evt_set = '0;
    endtask

    task automatic pulse_err(input logic [6:0] m);
        err_set = m; step(); err_set = '0;
    endtask

    task automatic check(input logic [23:0] act, input logic [23:0] e, input string t);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state and map
        bus_rd(S1, 16'h0000, "R1 sts1 after reset");
        bus_rd(CA, 16'h0000, "R1 ctrl A after reset");
        bus_rd(CB, 16'h0000, "R1 ctrl B after reset");
        bus_rd(3'd6, 16'h0000, "R1 unmapped address");
        check({21'd0, irq_evt, irq_buf, irq_err}, 24'd0, "R1 irqs low after reset");
        // R11 status word 2
        bus_rd(S2, 16'h5A05, "R11 sts2 pec and state");

        // R2 start flag, R10 event irq
        pulse_evt(5'h01);
        check({23'd0, irq_evt}, 24'd0, "R10 evt irq masked");
        bus_wr(CB, 16'h0100);
        check({23'd0, irq_evt}, 24'd1, "R10 evt irq enabled");
        bus_rd(S1, 16'h0001, "R2 start set");
        bus_rd(CA, 16'h0000, "R7 intervening read");
        bus_wr(DT, 16'h0033);
        bus_rd(S1, 16'h0001, "R7 start kept after broken sequence");
        bus_wr(DT, 16'h0033);
        bus_rd(S1, 16'h0000, "R2 start cleared by sts1 rd then data wr");
        check({23'd0, irq_evt}, 24'd0, "R10 evt irq drops");

        // R3 address flag
        pulse_evt(5'h02);
        bus_rd(S2, 16'h5A05, "R3 sts2 read alone");
        bus_rd(S1, 16'h0002, "R3 addr kept without sts1 read first");
        bus_rd(S2, 16'h5A05, "R3 sts2 read in sequence");
        bus_rd(S1, 16'h0000, "R3 addr cleared");

        // R4 byte flag, read and write variants
        pulse_evt(5'h04);
        bus_rd(S1, 16'h0004, "R4 byte set");
        bus_rd(DT, 16'h0033, "R4 data read");
        bus_rd(S1, 16'h0000, "R4 byte cleared by data read");
        pulse_evt(5'h04);
        bus_rd(S1, 16'h0004, "R4 byte set again");
        bus_wr(DT, 16'h0044);
        bus_rd(S1, 16'h0000, "R4 byte cleared by data write");

        // R5 header flag
        pulse_evt(5'h08);
        bus_rd(S1, 16'h0008, "R5 hdr set");
        bus_rd(DT, 16'h0044, "R5 data read");
        bus_rd(S1, 16'h0008, "R5 hdr kept after data read");
        bus_wr(DT, 16'h0055);
        bus_rd(S1, 16'h0000, "R5 hdr cleared by data write");

        // R6 stop flag
        pulse_evt(5'h10);
        bus_rd(S1, 16'h0010, "R6 stop set");
        bus_wr(CB, 16'h0100);
        bus_rd(S1, 16'h0010, "R6 stop kept after ctrl B write");
        bus_wr(CA, 16'h0000);
        bus_rd(S1, 16'h0000, "R6 stop cleared by ctrl A write");

        // R7 flag set after the arming read
        bus_rd(S1, 16'h0000, "R7 arming read with no flag");
        pulse_evt(5'h01);
        bus_wr(DT, 16'h0066);
        bus_rd(S1, 16'h0001, "R7 start set after read is kept");
        bus_wr(DT, 16'h0066);
        bus_rd(S1, 16'h0000, "R7 start cleared on proper sequence");

        // R9 set wins over sequence clear
        pulse_evt(5'h01);
        bus_rd(S1, 16'h0001, "R9 start armed");
        wr = 1'b1; addr = DT; wdata = 16'h0077; evt_set = 5'h01;
        step();
        wr = 1'b0; evt_set = '0;
        bus_rd(S1, 16'h0001, "R9 start kept when set meets clear");
        bus_wr(DT, 16'h0077);
        bus_rd(S1, 16'h0000, "R9 start cleared afterwards");

        // R8 error flags, R10 error irq
        pulse_err(7'h7F);
        bus_rd(S1, 16'h7F00, "R8 all errors set");
        check({23'd0, irq_err}, 24'd0, "R10 err irq masked");
        bus_wr(CB, 16'h0500);
        check({23'd0, irq_err}, 24'd1, "R10 err irq enabled");
        bus_wr(S1, 16'hFDFF);
        bus_rd(S1, 16'h7D00, "R8 write zero clears arbitration bit only");
        bus_wr(S1, 16'h0000);
        bus_rd(S1, 16'h0000, "R8 write zero clears all errors");
        check({23'd0, irq_err}, 24'd0, "R10 err irq drops");
        wr = 1'b1; addr = S1; wdata = 16'h0000; err_set = 7'h01;
        step();
        wr = 1'b0; err_set = '0;
        bus_rd(S1, 16'h0100, "R9 error set wins over write zero");
        bus_wr(S1, 16'h0000);
        bus_wr(S1, 16'hFFFF);
        bus_rd(S1, 16'h0000, "R8 write one sets nothing");

        // R10 buffer irq
        rx_full = 1'b1;
        step();
        check({23'd0, irq_buf}, 24'd0, "R10 buf irq masked");
        bus_rd(S1, 16'h0040, "R10 rx full visible");
        bus_wr(CB, 16'h0200);
        check({23'd0, irq_buf}, 24'd1, "R10 buf irq on rx full");
        rx_full = 1'b0; tx_empty = 1'b1;
        step();
        check({23'd0, irq_buf}, 24'd1, "R10 buf irq on tx empty");
        bus_rd(S1, 16'h0080, "R10 tx empty visible");
        tx_empty = 1'b0;
        step();
        check({23'd0, irq_buf}, 24'd0, "R10 buf irq drops");

        // R12 last event view, R11 new inputs
        pulse_evt(5'h02);
        pulse_err(7'h08);
        check(last_evt, 24'h050802, "R12 last event view");
        state = 3'b010; pec = 8'hC3;
        step();
        check(last_evt, 24'h020802, "R12 view excludes check byte");
        bus_rd(S2, 16'hC302, "R11 sts2 follows inputs");

        step();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule